// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the two timing strobes of a multiplexed external memory bus on an 8-bit microcontroller. The first is the address-latch pulse, which is high while the low address byte is valid. The second is the active-low program-read strobe. It runs from the oscillator-rate clock. A four-bit phase counter steps through a machine cycle of twelve oscillator periods: states S1 to S6, each with phases P1 and P2. Phase code 0 is S1P1 and phase code 11 is S6P2.

Four cycle flags describe the coming machine cycle:
- external code execution,
- a data-memory transfer (MOVX-type),
- a code-table read (MOVC-type),
- the latch-pulse disable bit.

The block samples these flags on the clock edge that starts a new machine cycle and holds them for all twelve periods. On cycles that carry a data-memory transfer, one latch pulse and both program-read pulses are suppressed. When the disable bit is set, the latch pulse runs only on table-read or data-transfer cycles. External execution overrides the disable bit.

Top module: `bus_strobe_seq`

## Requirements
- R1: `phase_o` counts 0,1,...,11 and then wraps to 0, advancing by one on every clock.
- R2: While `rst` is high, `ale_o` is 0 and `psen_n_o` is 1. The clock edge that sees `rst` high clears `phase_o` to 0 and clears all latched cycle flags.
- R3: On a cycle whose latch pulse is enabled and that carries no data transfer, `ale_o` is 1 exactly at phase codes 1, 2, 7 and 8. This gives two pulses per machine cycle, each two clocks wide.
- R4: On a cycle with `data_cyc` latched, and the latch pulse enabled, `ale_o` is 1 only at phase codes 1 and 2. The second pulse is omitted.
- R5: On a cycle with `ext_exec` latched and `data_cyc` clear, `psen_n_o` is 0 exactly at phase codes 3, 4, 5, 9, 10 and 11. This gives two pulses, each three clocks wide, that never overlap `ale_o`.
- R6: On a cycle with `data_cyc` latched, `psen_n_o` stays 1 for all twelve phases.
- R7: On a cycle with `ext_exec` clear, `psen_n_o` stays 1 for all twelve phases.
- R8: With `ale_off` latched and `ext_exec` clear, `ale_o` stays 0 for the whole cycle unless `table_rd` or `data_cyc` is latched. If either is latched, R3 or R4 applies.
- R9: With `ext_exec` latched, `ale_off` has no effect on `ale_o`.
- R10: The flags are sampled only on the edge where `phase_o` goes from 11 to 0. Changes at any other time have no effect until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_exec | input | 1 | Code is executed from external program memory |
| data_cyc | input | 1 | Coming machine cycle carries a data-memory transfer |
| table_rd | input | 1 | Coming machine cycle carries a code-table read |
| ale_off | input | 1 | Latch-pulse disable bit |
| ale_o | output | 1 | Address-latch pulse, active high |
| psen_n_o | output | 1 | Program-read strobe, active low |
| phase_o | output | 4 | Machine-cycle phase, 0 = S1P1 through 11 = S6P2 |

## Verification
The bench builds the block with its fixed twelve-period machine cycle. There are only four flags, so it sweeps all sixteen flag combinations. For each one it compares every phase of a full machine cycle against values computed from the pulse windows, and it also compares the number of pulses per cycle. A further pass flips every flag in the middle of a cycle, to show that only the boundary sample governs the strobes.

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_exec,
  input  logic       data_cyc,
  input  logic       table_rd,
  input  logic       ale_off,
  output logic       ale_o,
  output logic       psen_n_o,
  output logic [3:0] phase_o
);
  localparam logic [3:0] LAST = 4'd11;

  logic [3:0] ph;
  logic c_ext, c_dat, c_tab, c_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= 4'd0;
      c_ext <= 1'b0;
      c_dat <= 1'b0;
      c_tab <= 1'b0;
      c_off <= 1'b0;
    end else begin
      ph <= (ph == LAST) ? 4'd0 : ph + 4'd1;
      if (ph == LAST) begin
        c_ext <= ext_exec;
        c_dat <= data_cyc;
        c_tab <= table_rd;
        c_off <= ale_off;
      end
    end
  end

  logic win_a, win_b, ale_gate, fetch_win;
  assign win_a     = (ph == 4'd1) || (ph == 4'd2);
  assign win_b     = (ph == 4'd7) || (ph == 4'd8);
  assign ale_gate  = !c_off || c_ext || c_dat || c_tab;
  assign fetch_win = (ph >= 4'd3 && ph <= 4'd5) || (ph >= 4'd9);

  assign ale_o    = !rst && ale_gate && (win_a || (win_b && !c_dat));
  assign psen_n_o = rst || !(c_ext && !c_dat && fetch_win);
  assign phase_o  = ph;

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (ph == LAST) |=> (ph == 4'd0));
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    (ph != LAST) |=> (ph == $past(ph) + 4'd1));
  assert_ale_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ale_o) |=> ale_o);
  assert_ale_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (ale_o && $past(ale_o)) |=> !ale_o);
  assert_psen_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n_o) |=> !psen_n_o);
  assert_psen_end_R5: assert property (@(posedge clk) disable iff (rst)
    (!psen_n_o && !$past(psen_n_o) && !$past(psen_n_o, 2)) |=> psen_n_o);
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(ale_o && !psen_n_o));
  assert_data_no_psen_R6: assert property (@(posedge clk) disable iff (rst)
    c_dat |-> psen_n_o);
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ph != 4'd0) |-> $stable({c_ext, c_dat, c_tab, c_off}));
endmodule

// File: tb/sim_bus_strobe_seq.sv
module sim_bus_strobe_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_exec = 1'b0, data_cyc = 1'b0, table_rd = 1'b0, ale_off = 1'b0;
  logic ale_o, psen_n_o;
  logic [3:0] phase_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_strobe_seq u0 (.clk(clk), .rst(rst), .ext_exec(ext_exec), .data_cyc(data_cyc),
    .table_rd(table_rd), .ale_off(ale_off), .ale_o(ale_o), .psen_n_o(psen_n_o),
    .phase_o(phase_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_ale(int k, bit e, bit d, bit t, bit x);
    bit en = !x || e || d || t;
    return en && ((k == 1 || k == 2) || ((k == 7 || k == 8) && !d));
  endfunction

  function automatic bit exp_psen_n(int k, bit e, bit d);
    return !(e && !d && ((k >= 3 && k <= 5) || k >= 9));
  endfunction

  task automatic wait_last();
    do @(negedge clk); while (phase_o != 4'd11);
  endtask

  task automatic run_cycle(bit e, bit d, bit t, bit x, bit flip);
    int ale_rises = 0, psen_falls = 0;
    bit pa = 1'b0, pp = 1'b1;
    wait_last();
    ext_exec = e; data_cyc = d; table_rd = t; ale_off = x;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R1 phase", phase_o, k);
      chk(d ? "R4/R8 ale" : "R3/R8/R9 ale", ale_o, exp_ale(k, e, d, t, x));
      chk(d ? "R6 psen" : (e ? "R5 psen" : "R7 psen"), psen_n_o, exp_psen_n(k, e, d));
      if (ale_o && !pa) ale_rises++;
      if (!psen_n_o && pp) psen_falls++;
      pa = ale_o; pp = psen_n_o;
      if (flip && k == 5) begin
        ext_exec = !e; data_cyc = !d; table_rd = !t; ale_off = !x;
      end
    end
    chk(flip ? "R10 ale count" : "R3/R4 ale count", ale_rises,
        (!x || e || d || t) ? (d ? 1 : 2) : 0);
    chk(flip ? "R10 psen count" : "R5/R6 psen count", psen_falls, (e && !d) ? 2 : 0);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R2 ale in reset", ale_o, 0);
      chk("R2 psen in reset", psen_n_o, 1);
    end
    rst = 1'b0;
    @(negedge clk);
    chk("R2 phase after reset", phase_o, 1);
    for (int m = 0; m < 16; m++)
      run_cycle(m[3], m[2], m[1], m[0], 1'b0);
    for (int m = 0; m < 16; m++)
      run_cycle(m[3], m[2], m[1], m[0], 1'b1);
    rst = 1'b1;
    ext_exec = 1'b1; data_cyc = 1'b0; table_rd = 1'b0; ale_off = 1'b0;
    @(negedge clk);
    chk("R2 phase cleared", phase_o, 0);
    chk("R2 psen forced", psen_n_o, 1);
    rst = 1'b0;
    for (int k = 1; k < 12; k++) begin
      @(negedge clk);
      chk("R2 flags cleared psen", psen_n_o, 1);
    end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule